// File: doc/BRIEF.md
# TDM Frame Timing Generator

This block sets the frame timing for a multi-slot time-division audio port. It runs on a fast system clock and samples a bit clock that is already synchronous to it. From the edges of that bit clock it derives one strobe for the launch edge and one for the capture edge, and it keeps a bit counter that marks the position inside the frame. The transmit and receive paths share the strobes, the bit position and a frame-start pulse.

In master mode the block produces the frame sync itself. The sync can be short or long, and a short sync can sit early or late. In slave mode the block drives no sync. It samples an external sync on the capture edge and re-aligns its bit counter to that sync. A small write port holds the control word and the frame divider. A divider write is checked against the slot geometry presented by the data paths, and a divider that does not fit that geometry is refused.

Top module: `tdm_frame_gen`

## Requirements
- R1: Two registers are written through the write port. Address 0 holds the control word: bit 0 enable, bit 1 slave, bit 2 long sync, bit 3 early position, bit 5 polarity. Address 1 holds the divider in its low 16 bits. After reset the control word is all zero, the divider is 63, `fsync_o`, `bit_pos_o`, `frame_start_o` and `cfg_err_o` are 0, and the block is disabled.
- R2: A frame lasts divider+1 bit clocks. The bit position advances on each launch strobe and wraps from the divider value to 0.
- R3: With short sync and late position, the master sync is high for exactly one bit, the bit at position 0.
- R4: With short sync and early position, the master sync is high only during the last bit (position = divider), one bit before position 0.
- R5: With long sync, the master sync is high while the bit position is below the slot length.
- R6: With polarity 0 the launch strobe follows the bit-clock rise and the capture strobe follows the fall. With polarity 1 the two are swapped. The two strobes are never active together.
- R7: While enable is 0, both strobes stay low, the sync output stays low and the bit position is 0.
- R8: A divider write with divider+1 below slot length times slot count sets `cfg_err_o` and leaves the old divider in use. The next legal divider write clears `cfg_err_o` and applies the new value.
- R9: With long sync and a slot count of 1 or less, a divider write with divider+1 not above the slot length is refused and flagged as in R8.
- R10: In slave mode `fsync_o` stays low. A rising external sync seen on a capture strobe, with short-late or long sync, moves the bit position to 0.
- R11: In slave mode with short-early sync, a rising external sync seen on a capture strobe moves the bit position to the divider value, so the next launch strobe starts the frame.
- R12: `frame_start_o` pulses for one clock each time the bit position becomes 0 on a launch strobe. It also pulses when a slave re-alignment moves a non-zero position to 0. It is only ever high while the position is 0.
- R13: The early-position bit has no effect while long sync is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 divider |
| reg_wdata_i | input | 32 | Write data |
| slot_len_i | input | 6 | Slot length in bits, from the data paths |
| slot_cnt_i | input | 4 | Slots per frame, from the data paths |
| bclk_i | input | 1 | Bit clock, synchronous to clk_i |
| fsync_i | input | 1 | External frame sync (slave mode) |
| fsync_o | output | 1 | Generated frame sync (master mode) |
| frame_start_o | output | 1 | One-clock pulse at frame start |
| bit_pos_o | output | 16 | Current bit position in the frame |
| tx_edge_o | output | 1 | Launch strobe |
| rx_edge_o | output | 1 | Capture strobe |
| cfg_err_o | output | 1 | Last divider write was refused |

## Verification
The master sync is run with short-late, short-early, long, and long with the early bit set. Between them these patterns tell apart the sync position, the sync width, and whether the early bit wrongly leaks into long mode. A run with polarity 1 shows that the launch and capture strobes swap edges. A too-short divider and a long-sync single-slot divider must be refused, and the frame length seen afterwards proves that the old divider stayed in force. Slave runs place an external sync in the middle of a free-running count, so the late and early re-alignment targets and the frame-start pulse become visible. The disabled phases show that the bit clock moves nothing while enable is low.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
  localparam int unsigned CTRL_EN_BIT    = 0;
  localparam int unsigned CTRL_SLAVE_BIT = 1;
  localparam int unsigned CTRL_LONG_BIT  = 2;
  localparam int unsigned CTRL_EARLY_BIT = 3;
  localparam int unsigned CTRL_POL_BIT   = 5;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DIV  = 1'b1;

  typedef struct packed {
    logic pol;
    logic early;
    logic long_sync;
    logic slave;
    logic en;
  } tdm_ctrl_t;

  function automatic tdm_ctrl_t unpack_ctrl(input logic [5:0] w);
    tdm_ctrl_t c;
    c.en        = w[CTRL_EN_BIT];
    c.slave     = w[CTRL_SLAVE_BIT];
    c.long_sync = w[CTRL_LONG_BIT];
    c.early     = w[CTRL_EARLY_BIT];
    c.pol       = w[CTRL_POL_BIT];
    return c;
  endfunction
endpackage

// File: rtl/tdm_edge_det.sv
`timescale 1ns/1ps
module tdm_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic en_i,
  input  logic pol_i,
  output logic tx_stb_o,
  output logic rx_stb_o
);
  logic bclk_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_i;
  end

  assign rise = bclk_i & ~bclk_q;
  assign fall = ~bclk_i & bclk_q;

  // pol 0: launch on rise, capture on fall
  assign tx_stb_o = en_i & (pol_i ? fall : rise);
  assign rx_stb_o = en_i & (pol_i ? rise : fall);
endmodule

// File: rtl/tdm_cfg_regs.sv
`timescale 1ns/1ps
module tdm_cfg_regs
  import tdm_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned SLEN_W  = 6,
  parameter int unsigned SCNT_W  = 4,
  parameter int unsigned DIV_RST = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SLEN_W-1:0] slot_len_i,
  input  logic [SCNT_W-1:0] slot_cnt_i,
  output tdm_ctrl_t         ctrl_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              err_o
);
  localparam int unsigned PROD_W = SLEN_W + SCNT_W;
  localparam int unsigned CMP_W  = (DIV_W + 1 > PROD_W) ? DIV_W + 1 : PROD_W;

  tdm_ctrl_t        ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             err_q;

  logic [CMP_W-1:0] frame_len, need_len, slen_ext;
  logic             bad_geom, bad_long, bad_div;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:DIV_W];

  assign frame_len = CMP_W'(wdata_i[DIV_W-1:0]) + CMP_W'(1);
  assign need_len  = CMP_W'(slot_len_i) * CMP_W'(slot_cnt_i);
  assign slen_ext  = CMP_W'(slot_len_i);

  assign bad_geom = frame_len < need_len;
  assign bad_long = ctrl_q.long_sync && (slot_cnt_i <= SCNT_W'(1)) && (frame_len <= slen_ext);
  assign bad_div  = bad_geom | bad_long;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_RST);
      err_q  <= 1'b0;
    end else if (we_i) begin
      if (addr_i == ADDR_CTRL) begin
        ctrl_q <= unpack_ctrl(wdata_i[5:0]);
      end else begin
        err_q <= bad_div;
        if (!bad_div) div_q <= wdata_i[DIV_W-1:0];
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign div_o  = div_q;
  assign err_o  = err_q;
endmodule

// File: rtl/tdm_bit_counter.sv
`timescale 1ns/1ps
module tdm_bit_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             slave_i,
  input  logic             early_i,   // effective early (short sync only)
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_stb_i,
  input  logic             rx_stb_i,
  input  logic             fsync_i,
  output logic [DIV_W-1:0] pos_o,
  output logic             start_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, tgt;
  logic             fs_last_q, fs_last_d;
  logic             start_q, start_d;

  assign tgt = early_i ? div_i : '0;

  always_comb begin
    cnt_d     = cnt_q;
    fs_last_d = fs_last_q;
    start_d   = 1'b0;
    if (!en_i) begin
      cnt_d     = '0;
      fs_last_d = 1'b0;
    end else if (tx_stb_i) begin
      cnt_d   = (cnt_q >= div_i) ? '0 : cnt_q + DIV_W'(1);
      start_d = (cnt_d == '0);
    end else if (rx_stb_i) begin
      fs_last_d = fsync_i;
      // slave re-alignment on a rising external sync
      if (slave_i && fsync_i && !fs_last_q) begin
        cnt_d   = tgt;
        start_d = (tgt == '0) && (cnt_q != '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      fs_last_q <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      fs_last_q <= fs_last_d;
      start_q   <= start_d;
    end
  end

  assign pos_o   = cnt_q;
  assign start_o = start_q;
endmodule

// File: rtl/tdm_sync_gen.sv
`timescale 1ns/1ps
module tdm_sync_gen #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned SLEN_W = 6
) (
  input  logic              en_i,
  input  logic              master_i,
  input  logic              long_i,
  input  logic              early_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DIV_W-1:0]  pos_i,
  input  logic [SLEN_W-1:0] slot_len_i,
  output logic              fsync_o
);
  logic short_hit, long_hit;

  assign short_hit = early_i ? (pos_i == div_i) : (pos_i == '0);
  assign long_hit  = pos_i < DIV_W'(slot_len_i);
  assign fsync_o   = en_i & master_i & (long_i ? long_hit : short_hit);
endmodule

// File: rtl/tdm_frame_gen.sv
`timescale 1ns/1ps
module tdm_frame_gen
  import tdm_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned SLEN_W  = 6,
  parameter int unsigned SCNT_W  = 4,
  parameter int unsigned DIV_RST = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [SLEN_W-1:0] slot_len_i,
  input  logic [SCNT_W-1:0] slot_cnt_i,
  input  logic              bclk_i,
  input  logic              fsync_i,
  output logic              fsync_o,
  output logic              frame_start_o,
  output logic [DIV_W-1:0]  bit_pos_o,
  output logic              tx_edge_o,
  output logic              rx_edge_o,
  output logic              cfg_err_o
);
  tdm_ctrl_t        ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             tx_stb, rx_stb;
  logic             early_eff;

  assign early_eff = ctrl_q.early & ~ctrl_q.long_sync;

  tdm_cfg_regs #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W),
    .SLEN_W (SLEN_W),
    .SCNT_W (SCNT_W),
    .DIV_RST(DIV_RST)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .slot_len_i(slot_len_i),
    .slot_cnt_i(slot_cnt_i),
    .ctrl_o    (ctrl_q),
    .div_o     (div_q),
    .err_o     (cfg_err_o)
  );

  tdm_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bclk_i  (bclk_i),
    .en_i    (ctrl_q.en),
    .pol_i   (ctrl_q.pol),
    .tx_stb_o(tx_stb),
    .rx_stb_o(rx_stb)
  );

  tdm_bit_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl_q.en),
    .slave_i (ctrl_q.slave),
    .early_i (early_eff),
    .div_i   (div_q),
    .tx_stb_i(tx_stb),
    .rx_stb_i(rx_stb),
    .fsync_i (fsync_i),
    .pos_o   (bit_pos_o),
    .start_o (frame_start_o)
  );

  tdm_sync_gen #(.DIV_W(DIV_W), .SLEN_W(SLEN_W)) u_sync (
    .en_i      (ctrl_q.en),
    .master_i  (~ctrl_q.slave),
    .long_i    (ctrl_q.long_sync),
    .early_i   (early_eff),
    .div_i     (div_q),
    .pos_i     (bit_pos_o),
    .slot_len_i(slot_len_i),
    .fsync_o   (fsync_o)
  );

  assign tx_edge_o = tx_stb;
  assign rx_edge_o = rx_stb;
endmodule

// File: rtl/tdm_frame_gen_chk.sv
`timescale 1ns/1ps
module tdm_frame_gen_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic             en_i,
  input logic             slave_i,
  input logic             long_i,
  input logic [DIV_W-1:0] div_i,
  input logic             fsync_i,
  input logic [DIV_W-1:0] bit_pos_i,
  input logic             start_i,
  input logic             tx_i,
  input logic             rx_i,
  input logic             err_i
);
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tx_i && !reg_we_i && bit_pos_i == div_i) |=> (bit_pos_i == '0));

  p_short_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !slave_i && !long_i && div_i != '0 && fsync_i && tx_i && !reg_we_i) |=> !fsync_i);

  p_edge_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_i && rx_i));

  p_idle_pos_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (bit_pos_i == '0));

  p_idle_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !fsync_i);

  p_err_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> $stable(div_i));

  p_slave_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_i |-> !fsync_i);

  p_start_pos_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (bit_pos_i == '0));
endmodule

bind tdm_frame_gen tdm_frame_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .reg_we_i (reg_we_i),
  .en_i     (ctrl_q.en),
  .slave_i  (ctrl_q.slave),
  .long_i   (ctrl_q.long_sync),
  .div_i    (div_q),
  .fsync_i  (fsync_o),
  .bit_pos_i(bit_pos_o),
  .start_i  (frame_start_o),
  .tx_i     (tx_edge_o),
  .rx_i     (rx_edge_o),
  .err_i    (cfg_err_o)
);

// File: tb/tdm_frame_gen_bench.sv
`timescale 1ns/1ps
module tdm_frame_gen_bench;
  localparam int H = 3;

  typedef struct {
    logic        fs;
    logic [15:0] pos;
    logic        st;
    string       tag;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_addr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [5:0]  slot_len_i = 6'd4;
  logic [3:0]  slot_cnt_i = 4'd2;
  logic        bclk_i = 1'b0;
  logic        fsync_i = 1'b0;
  logic        fsync_o, frame_start_o, tx_edge_o, rx_edge_o, cfg_err_o;
  logic [15:0] bit_pos_o;

  int n_chk = 0;
  int n_fail = 0;
  item_t exp_q[$];

  // bench model state
  logic m_en = 0, m_slave = 0, m_long = 0, m_early = 0, m_pol = 0, m_err = 0;
  logic m_bclk = 0, m_fs_last = 0;
  int   m_div = 63;
  int   m_pos = 0;
  bit   chk_edges = 0;

  always #2.5 clk_i = ~clk_i;

  tdm_frame_gen u_tdm_frame_gen (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .slot_len_i, .slot_cnt_i, .bclk_i, .fsync_i,
    .fsync_o, .frame_start_o, .bit_pos_o, .tx_edge_o, .rx_edge_o, .cfg_err_o
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic exp_fs();
    if (!m_en || m_slave) return 1'b0;
    if (m_long) return m_pos < int'(slot_len_i);
    if (m_early) return m_pos == m_div;
    return m_pos == 0;
  endfunction

  task automatic wr(input logic a, input logic [31:0] d, input string tag);
    int fl, need;
    bit bad;
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (a == 1'b0) begin
      m_en = d[0]; m_slave = d[1]; m_long = d[2]; m_early = d[3]; m_pol = d[5];
      if (!m_en) begin m_pos = 0; m_fs_last = 0; end
    end else begin
      fl   = int'(d[15:0]) + 1;
      need = int'(slot_len_i) * int'(slot_cnt_i);
      bad  = (fl < need) || (m_long && slot_cnt_i <= 1 && fl <= int'(slot_len_i));
      m_err = bad;
      if (!bad) m_div = int'(d[15:0]);
      check(cfg_err_o == m_err, tag, cfg_err_o, m_err);
    end
  endtask

  // one half period of the bit clock; pushes the expected outputs
  task automatic half(input logic v, input logic fs, input string tag);
    bit is_rise, is_fall, tx_e, rx_e, st, rs;
    int tgt;
    item_t it;
    @(negedge clk_i);
    bclk_i = v; fsync_i = fs;
    #1;
    is_rise = v && !m_bclk;
    is_fall = !v && m_bclk;
    tx_e = m_en && (m_pol ? is_fall : is_rise);
    rx_e = m_en && (m_pol ? is_rise : is_fall);
    if (chk_edges)
      check(tx_edge_o == tx_e && rx_edge_o == rx_e, tag,
            {tx_edge_o, rx_edge_o}, {tx_e, rx_e});
    @(posedge clk_i);
    st = 0;
    if (!m_en) begin
      m_pos = 0; m_fs_last = 0;
    end else if (tx_e) begin
      m_pos = (m_pos >= m_div) ? 0 : m_pos + 1;
      st = (m_pos == 0);
    end else if (rx_e) begin
      rs = fs && !m_fs_last;
      m_fs_last = fs;
      if (m_slave && rs) begin
        tgt = (m_early && !m_long) ? m_div : 0;
        st = (tgt == 0) && (m_pos != 0);
        m_pos = tgt;
      end
    end
    m_bclk = v;
    it.fs = exp_fs(); it.pos = 16'(m_pos); it.st = st; it.tag = tag;
    exp_q.push_back(it);
    repeat (H) @(posedge clk_i);
  endtask

  task automatic bits(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      half(1'b1, 1'b0, tag);
      half(1'b0, 1'b0, tag);
    end
  endtask

  task automatic slave_run(input string tag);
    for (int b = 0; b < 40; b++) begin
      half(1'b1, (b == 5 || b == 21), tag);
      half(1'b0, (b == 5 || b == 21), tag);
    end
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      @(negedge clk_i);
      if (exp_q.size() != 0) begin
        it = exp_q.pop_front();
        check(fsync_o == it.fs, {it.tag, " fsync"}, fsync_o, it.fs);
        check(bit_pos_o == it.pos, {it.tag, " pos"}, bit_pos_o, it.pos);
        check(frame_start_o == it.st, {it.tag, " R12 start"}, frame_start_o, it.st);
      end
    end
  end

  initial begin
    #(5ns * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(fsync_o == 0 && bit_pos_o == 0 && frame_start_o == 0 && cfg_err_o == 0,
          "R1 reset", {fsync_o, frame_start_o, cfg_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(bit_pos_o == 0 && tx_edge_o == 0, "R1 after release", bit_pos_o, 0);

    // R7: disabled, bit clock has no effect
    chk_edges = 1;
    bits(4, "R7");
    chk_edges = 0;

    // R2/R3: master short late, frame of 8
    wr(1'b1, 32'd7, "R2 div");
    wr(1'b0, 32'h01, "R3 ctrl");
    bits(20, "R3");
    // R4: short early
    wr(1'b0, 32'h09, "R4 ctrl");
    bits(12, "R4");
    // R5: long
    wr(1'b0, 32'h05, "R5 ctrl");
    bits(12, "R5");
    // R13: early has no effect with long
    wr(1'b0, 32'h0D, "R13 ctrl");
    bits(12, "R13");
    // R6: polarity swap
    wr(1'b0, 32'h21, "R6 ctrl");
    chk_edges = 1;
    bits(10, "R6");
    chk_edges = 0;
    wr(1'b0, 32'h01, "R2 ctrl");
    chk_edges = 1;
    bits(3, "R6");
    chk_edges = 0;

    // R8: divider too short for 4x2 slots
    wr(1'b1, 32'd5, "R8 bad div");
    bits(10, "R8");
    wr(1'b1, 32'd9, "R8 good div");
    bits(12, "R2");

    // R9: long sync, single slot
    wr(1'b0, 32'h05, "R9 ctrl");
    slot_len_i = 6'd8; slot_cnt_i = 4'd1;
    wr(1'b1, 32'd7, "R9 bad div");
    wr(1'b1, 32'd8, "R9 good div");
    bits(12, "R9");

    // R10: slave, late
    slot_len_i = 6'd4; slot_cnt_i = 4'd2;
    wr(1'b0, 32'h00, "R7 ctrl");
    bits(2, "R7");
    wr(1'b1, 32'd15, "R10 div");
    wr(1'b0, 32'h03, "R10 ctrl");
    slave_run("R10");
    // R11: slave, early
    wr(1'b0, 32'h00, "R7 ctrl");
    wr(1'b0, 32'h0B, "R11 ctrl");
    slave_run("R11");

    wr(1'b0, 32'h00, "R7 ctrl");
    chk_edges = 1;
    bits(3, "R7");
    chk_edges = 0;

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule